// File: doc/BRIEF.md
# Selectable Static/Dynamic Branch Direction Predictor

This block guesses the direction of conditional branches in the decode stage of an in-order pipeline. A decode strobe presents the branch's fetch address and its displacement field. One cycle later the block returns a registered taken/not-taken guess. A run-time mode input picks the method. In static mode, a branch that points backwards (negative displacement) is guessed taken. In dynamic mode, the guess comes from a table of 2-bit saturating counters, indexed by low bits of the fetch address.

When a branch resolves, the pipeline returns its address, its real outcome and the direction that was guessed for it. In dynamic mode the matching counter is trained. In either mode, a wrong guess raises a redirect request that also holds issue for a fixed recovery window. While that window is open, new decode strobes are ignored. Computing the target address, the return stack and instruction fetch are not part of this block.

Top module: `bpred_sel`

## Requirements
- R1: After reset, pred_valid and redirect are 0 and every table counter holds 01 (weakly not taken), so every dynamic guess is not taken until training.
- R2: In static mode, an accepted decode gives pred_valid=1 one cycle later, with pred_taken equal to the most significant bit of dec_disp (1 = backward = taken). pred_taken is 0 whenever pred_valid is 0.
- R3: In dynamic mode, the counter selected by dec_pc[13:2] gives the guess one cycle after an accepted decode: values 2 and 3 mean taken, values 0 and 1 mean not taken. Addresses that differ only outside bits [13:2] share a counter.
- R4: A resolution in dynamic mode increments the counter at res_pc[13:2] when res_taken=1 and decrements it when res_taken=0. The counter saturates at 3 and at 0.
- R5: A resolution in static mode leaves the table unchanged.
- R6: When a decode and a dynamic update address the same counter in the same cycle, the guess uses the counter value from before the update.
- R7: A resolution with res_taken different from res_pred_taken raises redirect for exactly 4 cycles, starting in the cycle after the resolution. A resolution with res_taken equal to res_pred_taken raises nothing.
- R8: A new wrong resolution during an open redirect window restarts the window at the full 4 cycles.
- R9: A decode strobe presented while redirect is 1 is ignored, so pred_valid is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dyn_mode | input | 1 | 1 = counter table, 0 = displacement sign |
| dec_valid | input | 1 | Branch present in decode |
| dec_pc | input | PC_W | Fetch address of the decoded branch |
| dec_disp | input | DISP_W | Displacement field of the decoded branch |
| res_valid | input | 1 | Branch resolution strobe |
| res_pc | input | PC_W | Fetch address of the resolved branch |
| res_taken | input | 1 | Actual outcome |
| res_pred_taken | input | 1 | Direction that was guessed for this branch |
| pred_valid | output | 1 | Guess available this cycle |
| pred_taken | output | 1 | Guessed direction |
| redirect | output | 1 | Misprediction recovery; issue held while set |

## Verification
The guess is due one cycle after the decode strobe. A table update is visible to a decode strobe from the cycle after the resolution, and redirect rises in the cycle after a wrong resolution and stays up for four cycles. The bench drives inputs on the falling edge and reads outputs on the next falling edge, which is one rising edge later. It reads the redirect window on the falling edges that follow, counting cycles so the window is checked for both its length and its end. Training effects are read back through later guesses at the same or aliasing addresses.

// File: rtl/bpred_sel.sv
module bpred_sel #(
  parameter int PC_W    = 32,
  parameter int DISP_W  = 21,
  parameter int IDX_LSB = 2,
  parameter int IDX_W   = 12,
  parameter int PENALTY = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dyn_mode,
  input  logic              dec_valid,
  input  logic [PC_W-1:0]   dec_pc,
  input  logic [DISP_W-1:0] dec_disp,
  input  logic              res_valid,
  input  logic [PC_W-1:0]   res_pc,
  input  logic              res_taken,
  input  logic              res_pred_taken,
  output logic              pred_valid,
  output logic              pred_taken,
  output logic              redirect
);

  localparam int DEPTH = 1 << IDX_W;
  localparam int CW    = $clog2(PENALTY + 1);

  logic [1:0]       tbl [DEPTH];
  logic [CW-1:0]    hold_cnt;
  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic [1:0]       cur, nxt;
  logic             accept, miss, upd;

  assign rd_idx = dec_pc[IDX_LSB +: IDX_W];
  assign wr_idx = res_pc[IDX_LSB +: IDX_W];
  assign accept = dec_valid && !redirect;
  assign miss   = res_valid && (res_taken != res_pred_taken);
  assign upd    = res_valid && dyn_mode;
  assign cur    = tbl[wr_idx];
  assign nxt    = res_taken ? ((cur == 2'b11) ? cur : cur + 2'd1)
                            : ((cur == 2'b00) ? cur : cur - 2'd1);
  assign redirect = (hold_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= 2'b01;
    end else if (upd) begin
      tbl[wr_idx] <= nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pred_valid <= 1'b0;
      pred_taken <= 1'b0;
    end else begin
      pred_valid <= accept;
      pred_taken <= accept && (dyn_mode ? tbl[rd_idx][1] : dec_disp[DISP_W-1]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          hold_cnt <= '0;
    else if (miss)       hold_cnt <= CW'(PENALTY);
    else if (redirect)   hold_cnt <= hold_cnt - 1'b1;
  end

  logic [IDX_W-1:0] chk_idx;
  logic [1:0]       chk_old;
  logic             chk_static, chk_hi, chk_lo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_idx    <= '0;
      chk_old    <= 2'b01;
      chk_static <= 1'b0;
      chk_hi     <= 1'b0;
      chk_lo     <= 1'b0;
    end else begin
      chk_idx    <= wr_idx;
      chk_old    <= cur;
      chk_static <= res_valid && !dyn_mode;
      chk_hi     <= upd && res_taken && (cur == 2'b11);
      chk_lo     <= upd && !res_taken && (cur == 2'b00);
    end
  end

  AST_TAKEN_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    pred_taken |-> pred_valid); // R2
  AST_PRED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !redirect) |=> pred_valid); // R2
  AST_STATIC_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !redirect && !dyn_mode) |=> (pred_taken == $past(dec_disp[DISP_W-1]))); // R2
  AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    chk_hi |-> (tbl[chk_idx] == 2'b11)); // R4
  AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    chk_lo |-> (tbl[chk_idx] == 2'b00)); // R4
  AST_STATIC_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    chk_static |-> (tbl[chk_idx] == chk_old)); // R5
  AST_MISS_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && (res_taken != res_pred_taken)) |=> redirect); // R7
  AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> !pred_valid); // R9

endmodule

// File: tb/bpred_sel_test.sv
module bpred_sel_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        dyn_mode, dec_valid, res_valid, res_taken, res_pred_taken;
  logic [31:0] dec_pc, res_pc;
  logic [20:0] dec_disp;
  logic        pred_valid, pred_taken, redirect;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  bpred_sel uut (
    .clk(clk), .rst_n(rst_n), .dyn_mode(dyn_mode),
    .dec_valid(dec_valid), .dec_pc(dec_pc), .dec_disp(dec_disp),
    .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
    .res_pred_taken(res_pred_taken),
    .pred_valid(pred_valid), .pred_taken(pred_taken), .redirect(redirect)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic predict(input logic [31:0] pc, input logic [20:0] disp, input logic mode,
                         output logic v, output logic t);
    @(negedge clk);
    dec_valid = 1'b1; dec_pc = pc; dec_disp = disp; dyn_mode = mode;
    @(negedge clk);
    dec_valid = 1'b0;
    v = pred_valid; t = pred_taken;
  endtask

  task automatic resolve(input logic [31:0] pc, input logic tk, input logic mode);
    @(negedge clk);
    res_valid = 1'b1; res_pc = pc; res_taken = tk; res_pred_taken = tk; dyn_mode = mode;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic v, t;
    check("R1 pred_valid after reset", pred_valid, 0);
    check("R1 redirect after reset", redirect, 0);
    predict(32'h0000_1000, 21'h1F_FFFF, 1'b1, v, t);
    check("R1 dynamic initial guess", t, 0);
    predict(32'h0000_3FFC, 21'h0, 1'b1, v, t);
    check("R1 dynamic initial guess top index", t, 0);
  endtask

  task automatic t_static;
    logic v, t;
    predict(32'h0000_2000, 21'h10_0000, 1'b0, v, t);
    check("R2 valid one cycle after decode", v, 1);
    check("R2 negative displacement taken", t, 1);
    predict(32'h0000_2000, 21'h0F_FFFF, 1'b0, v, t);
    check("R2 positive displacement not taken", t, 0);
    @(negedge clk);
    check("R2 no strobe no valid", pred_valid, 0);
    check("R2 no strobe not taken", pred_taken, 0);
  endtask

  task automatic t_dynamic;
    logic v, t;
    resolve(32'h0000_0100, 1'b1, 1'b1);
    predict(32'h0000_0100, 21'h0F_0000, 1'b1, v, t);
    check("R3 counter 2 taken", t, 1);
    predict(32'h0000_4100, 21'h0, 1'b1, v, t);
    check("R3 alias outside [13:2] shares counter", t, 1);
    predict(32'h0000_0104, 21'h0, 1'b1, v, t);
    check("R3 neighbour index untouched", t, 0);
    resolve(32'h0000_0100, 1'b1, 1'b1);
    resolve(32'h0000_0100, 1'b1, 1'b1);
    resolve(32'h0000_0100, 1'b0, 1'b1);
    predict(32'h0000_0100, 21'h0, 1'b1, v, t);
    check("R4 saturate at 3 then one decrement still taken", t, 1);
    resolve(32'h0000_0100, 1'b0, 1'b1);
    predict(32'h0000_0100, 21'h0, 1'b1, v, t);
    check("R4 second decrement not taken", t, 0);
    for (int i = 0; i < 3; i++) resolve(32'h0000_0100, 1'b0, 1'b1);
    resolve(32'h0000_0100, 1'b1, 1'b1);
    predict(32'h0000_0100, 21'h0, 1'b1, v, t);
    check("R4 saturate at 0 then one increment not taken", t, 0);
    resolve(32'h0000_0100, 1'b1, 1'b1);
    predict(32'h0000_0100, 21'h0, 1'b1, v, t);
    check("R4 second increment taken", t, 1);
  endtask

  task automatic t_static_no_update;
    logic v, t;
    resolve(32'h0000_0200, 1'b1, 1'b0);
    resolve(32'h0000_0200, 1'b1, 1'b0);
    predict(32'h0000_0200, 21'h0, 1'b1, v, t);
    check("R5 static resolutions leave counter", t, 0);
  endtask

  task automatic t_collision;
    @(negedge clk);
    dyn_mode = 1'b1;
    dec_valid = 1'b1; dec_pc = 32'h0000_0300; dec_disp = 21'h0;
    res_valid = 1'b1; res_pc = 32'h0000_0300; res_taken = 1'b1; res_pred_taken = 1'b1;
    @(negedge clk);
    dec_valid = 1'b0; res_valid = 1'b0;
    check("R6 same-cycle guess valid", pred_valid, 1);
    check("R6 same-cycle guess uses old counter", pred_taken, 0);
    dec_valid = 1'b1;
    @(negedge clk);
    dec_valid = 1'b0;
    check("R6 next guess sees update", pred_taken, 1);
  endtask

  task automatic t_redirect;
    resolve(32'h0000_0400, 1'b1, 1'b0);
    check("R7 correct resolution no redirect", redirect, 0);
    @(negedge clk);
    res_valid = 1'b1; res_pc = 32'h0000_0400; res_taken = 1'b1; res_pred_taken = 1'b0;
    dyn_mode = 1'b0;
    @(negedge clk);
    res_valid = 1'b0;
    for (int i = 0; i < 5; i++) begin
      check($sformatf("R7 redirect cycle %0d", i + 1), redirect, (i < 4) ? 1 : 0);
      @(negedge clk);
    end
  endtask

  task automatic t_restart;
    int n = 0;
    @(negedge clk);
    res_valid = 1'b1; res_pc = 32'h0000_0500; res_taken = 1'b0; res_pred_taken = 1'b1;
    dyn_mode = 1'b0;
    @(negedge clk);
    res_valid = 1'b0;
    if (redirect) n++;
    @(negedge clk);
    if (redirect) n++;
    res_valid = 1'b1;
    @(negedge clk);
    res_valid = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (redirect) n++;
      @(negedge clk);
    end
    check("R8 restarted window total cycles", n, 6);
    check("R8 window closed", redirect, 0);
  endtask

  task automatic t_hold;
    logic v, t;
    @(negedge clk);
    res_valid = 1'b1; res_pc = 32'h0000_0600; res_taken = 1'b1; res_pred_taken = 1'b0;
    dyn_mode = 1'b0;
    @(negedge clk);
    res_valid = 1'b0;
    dec_valid = 1'b1; dec_pc = 32'h0000_0600; dec_disp = 21'h1F_0000;
    @(negedge clk);
    dec_valid = 1'b0;
    check("R9 decode during redirect ignored", pred_valid, 0);
    for (int i = 0; i < 4; i++) @(negedge clk);
    check("R9 redirect cleared", redirect, 0);
    predict(32'h0000_0600, 21'h1F_0000, 1'b0, v, t);
    check("R9 decode accepted after window", v, 1);
  endtask

  initial begin
    rst_n = 1'b0; dyn_mode = 1'b0; dec_valid = 1'b0; res_valid = 1'b0;
    res_taken = 1'b0; res_pred_taken = 1'b0;
    dec_pc = '0; res_pc = '0; dec_disp = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_static;
    t_dynamic;
    t_static_no_update;
    t_collision;
    t_redirect;
    t_restart;
    t_hold;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule